// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Controller

This block connects a synchronous host to a 32-bit asynchronous static memory made of four independent 8-bit lanes. All four lanes share the address lines and a single active-low output enable. Each lane has its own active-low chip enable and write enable. The host issues one word request at a time on a valid/ready port. A 4-bit byte mask goes with each request, so any mix of lanes (8, 16, 24 or 32 bits) takes part in one access. Mask bit i selects lane i, which carries data bits [8i+7:8i].

Each analog minimum or maximum from the memory's timing is given in nanoseconds as a parameter. The block turns it into a cycle count by ceiling division by the clock period, with a floor of one cycle. The controller then holds each strobe phase for that many cycles.

Writes keep the output enable high for their whole duration, so the controller may drive the data bus in the cycle in which write enable falls. Reads return their data through a one-cycle response pulse.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is active and after it is released, every chip enable, every write enable and the output enable are high, the bus drive is low, no response is signalled and the host ready is high.
- R2: A request is taken only on a clock edge where reqValid and reqReady are both high. reqReady then stays low until the access and its recovery phase are complete (3 busy cycles for a read and 4 for a write at the default parameters).
- R3: During a read, the chip enables equal the inverted mask, the output enable is low and all write enables are high. This phase lasts max(access, cycle time) cycles, which is 2 at the defaults.
- R4: Read data is sampled on the clock edge that ends the last read cycle. It appears on rspData together with a single-cycle rspValid in the next cycle. Lanes whose mask bit is 0 return zero.
- R5: During a write pulse, the selected lanes have both chip enable and write enable low, the output enable is high and the bus is driven. The pulse lasts max(pulse width, data setup) cycles, which is 2 at the defaults.
- R6: After the write pulse, all enables go high while the address and the driven data are held for the hold phase. This phase lasts at least one cycle and is long enough that the whole write covers the minimum cycle time (1 cycle at the defaults).
- R7: memAddr equals the accepted request address for the whole access. Lanes whose mask bit is 0 never see chip enable or write enable low.
- R8: Every access ends with a recovery phase in which all strobes are high. It lasts at least the write-enable high time and the output-disable time, and at least one cycle, before the next request can be accepted.
- R9: The controller never drives the data bus while the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqMask | input | 4 | Byte-lane select, bit i = lane i |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | One-cycle read data valid |
| rspData | output | 32 | Read data, unselected lanes zero |
| memAddr | output | 19 | Shared memory address |
| memCeN | output | 4 | Per-lane chip enable, active low |
| memWeN | output | 4 | Per-lane write enable, active low |
| memOeN | output | 1 | Shared output enable, active low |
| memDout | output | 32 | Data to memory |
| memDrive | output | 1 | Data bus drive enable |
| memDin | input | 32 | Data from memory |

## Verification
A wrong state or counter value in the sequencer shows up within the same access at the pins. Depending on the fault, a strobe phase comes out one cycle too short or too long, the output enable is low while the bus is driven, or the busy window has the wrong length. A bad lane decode puts a chip enable or write enable on an unmasked lane within the first cycle of the access. A wrong capture point returns stale or foreign lane data one cycle after the read phase ends, which the bench compares against its own reference image of the memory.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef struct packed {
    logic load;     // latch request fields
    logic selOn;    // assert chip enables on masked lanes
    logic weOn;     // assert write enables on masked lanes
    logic oeOn;     // assert shared output enable
    logic drive;    // drive data bus
    logic capture;  // sample read data
  } strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WPULSE,
    ST_WHOLD,
    ST_RECOVER
  } phase_t;

  // nanoseconds to cycles, ceiling, at least one
  function automatic int unsigned nsToCyc(input int unsigned ns, input int unsigned clkNs);
    int unsigned c;
    c = (ns + clkNs - 1) / clkNs;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned RD_N  = 2,
  parameter int unsigned WP_N  = 2,
  parameter int unsigned WH_N  = 1,
  parameter int unsigned GAP_N = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t st
);

  localparam int unsigned MAX_N = maxOf(maxOf(RD_N, WP_N), maxOf(WH_N, GAP_N));
  localparam int unsigned CNT_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

  phase_t            phase, phaseNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic              cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    phaseNxt = phase;
    cntNxt   = cntZero ? cnt : cnt - 1'b1;
    st       = '0;
    reqReady = 1'b0;
    unique case (phase)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          st.load = 1'b1;
          if (reqWrite) begin
            phaseNxt = ST_WPULSE;
            cntNxt   = CNT_W'(WP_N - 1);
          end else begin
            phaseNxt = ST_READ;
            cntNxt   = CNT_W'(RD_N - 1);
          end
        end
      end
      ST_READ: begin
        st.selOn = 1'b1;
        st.oeOn  = 1'b1;
        if (cntZero) begin
          st.capture = 1'b1;
          phaseNxt   = ST_RECOVER;
          cntNxt     = CNT_W'(GAP_N - 1);
        end
      end
      ST_WPULSE: begin
        st.selOn = 1'b1;
        st.weOn  = 1'b1;
        st.drive = 1'b1;
        if (cntZero) begin
          phaseNxt = ST_WHOLD;
          cntNxt   = CNT_W'(WH_N - 1);
        end
      end
      ST_WHOLD: begin
        st.drive = 1'b1;
        if (cntZero) begin
          phaseNxt = ST_RECOVER;
          cntNxt   = CNT_W'(GAP_N - 1);
        end
      end
      ST_RECOVER: begin
        if (cntZero) phaseNxt = ST_IDLE;
      end
      default: phaseNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNxt;
      cnt   <= cntNxt;
    end
  end

endmodule

// File: rtl/sram_lane_dp.sv
module sram_lane_dp
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memCeN,
  output logic [LANES-1:0]  memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDrive,
  input  logic [DATA_W-1:0] memDin
);

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] laneBits;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneBits[l*LANE_W +: LANE_W] = {LANE_W{maskQ[l]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      maskQ    <= '0;
      wdataQ   <= '0;
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      if (st.load) begin
        addrQ  <= reqAddr;
        maskQ  <= reqMask;
        wdataQ <= reqWdata;
      end
      if (st.capture) rspData <= memDin & laneBits;
      rspValid <= st.capture;
    end
  end

  assign memAddr  = addrQ;
  assign memDout  = wdataQ;
  assign memCeN   = st.selOn ? ~maskQ : '1;
  assign memWeN   = st.weOn  ? ~maskQ : '1;
  assign memOeN   = ~st.oeOn;
  assign memDrive = st.drive;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned LANES      = 4,
  parameter int unsigned LANE_W     = 8,
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned T_CYCLE_NS = 17,
  parameter int unsigned T_ACC_NS   = 17,
  parameter int unsigned T_WP_NS    = 12,
  parameter int unsigned T_DS_NS    = 7,
  parameter int unsigned T_DH_NS    = 2,
  parameter int unsigned T_AH_NS    = 2,
  parameter int unsigned T_WHI_NS   = 3,
  parameter int unsigned T_OEZ_NS   = 7,
  localparam int unsigned DATA_W    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memCeN,
  output logic [LANES-1:0]  memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDrive,
  input  logic [DATA_W-1:0] memDin
);

  localparam int unsigned CYC_N = nsToCyc(T_CYCLE_NS, CLK_NS);
  localparam int unsigned RD_N  = maxOf(nsToCyc(T_ACC_NS, CLK_NS), CYC_N);
  localparam int unsigned WP_N  = maxOf(nsToCyc(T_WP_NS, CLK_NS), nsToCyc(T_DS_NS, CLK_NS));
  localparam int unsigned WH_0  = maxOf(nsToCyc(T_DH_NS, CLK_NS), nsToCyc(T_AH_NS, CLK_NS));
  localparam int unsigned WH_N  = (WP_N + WH_0 >= CYC_N) ? WH_0 : CYC_N - WP_N;
  localparam int unsigned GAP_N = maxOf(nsToCyc(T_WHI_NS, CLK_NS), nsToCyc(T_OEZ_NS, CLK_NS));

  strobe_t st;

  sram_lane_fsm #(
    .RD_N(RD_N), .WP_N(WP_N), .WH_N(WH_N), .GAP_N(GAP_N)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .st(st)
  );

  sram_lane_dp #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .reqAddr(reqAddr), .reqMask(reqMask), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memDout(memDout), .memDrive(memDrive), .memDin(memDin)
  );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LANES-1:0]  memCeN,
  input logic [LANES-1:0]  memWeN,
  input logic              memOeN,
  input logic              memDrive
);

  // R9
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDrive |-> memOeN);

  // R5
  write_oe_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWeN != '1) |-> (memOeN && memDrive));

  // R3
  read_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN == '1));

  // R4
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R7
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((memCeN != '1) && $past(memCeN != '1)) |-> $stable(memAddr));

  // R8
  no_ready_while_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN == '1 && memWeN == '1 && memOeN && !memDrive));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN),
  .memOeN(memOeN), .memDrive(memDrive)
);

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [3:0]  reqMask = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic [18:0] memAddr;
  logic [3:0]  memCeN, memWeN;
  logic        memOeN;
  logic [31:0] memDout;
  logic        memDrive;
  logic [31:0] memDin;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] mdl [16][4];   // memory array the DUT talks to
  logic [7:0] refm[16][4];   // bench's expected image

  always #5 clk = ~clk;

  sram_lane_ctrl u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqMask(reqMask), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memAddr(memAddr), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memDout(memDout), .memDrive(memDrive),
    .memDin(memDin)
  );

  // memory model: lane outputs only when read-selected, else filler
  always_comb begin
    for (int l = 0; l < 4; l++)
      memDin[l*8 +: 8] = (!memCeN[l] && !memOeN && memWeN[l]) ? mdl[memAddr[3:0]][l] : 8'hA5;
  end

  always @(posedge clk) begin
    for (int l = 0; l < 4; l++)
      if (!memCeN[l] && !memWeN[l] && memDrive)
        mdl[memAddr[3:0]][l] <= memDout[l*8 +: 8];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [18:0] a, input logic [3:0] m);
    logic [31:0] r = '0;
    for (int l = 0; l < 4; l++) if (m[l]) r[l*8 +: 8] = refm[a[3:0]][l];
    return r;
  endfunction

  task automatic doReq(input bit wr, input logic [18:0] a, input logic [3:0] m, input logic [31:0] d);
    int cyc = 0;
    int weLow[4] = '{0, 0, 0, 0};
    int rspCnt = 0;
    int rspAt = -1;
    int oeLow = 0;
    bit ceOk = 1, addrOk = 1, driveOk = 1, holdOk = 1;
    logic [31:0] got = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqMask = m; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr = $urandom; reqMask = $urandom; reqWdata = $urandom;  // must not matter now
    while (!reqReady && cyc < 50) begin
      if (memCeN != 4'hF && memCeN != ~m) ceOk = 0;
      if ((memCeN != 4'hF || memDrive) && memAddr != a) addrOk = 0;
      if (!memOeN) oeLow++;
      if (wr && cyc == 2 && !(memDrive && memCeN == 4'hF && memWeN == 4'hF && memDout == d)) holdOk = 0;
      if (memDrive && !wr) driveOk = 0;
      for (int l = 0; l < 4; l++) if (!memWeN[l]) weLow[l]++;
      if (rspValid) begin rspCnt++; rspAt = cyc; got = rspData; end
      cyc++;
      @(negedge clk);
    end
    // R2: busy window length
    chk(cyc == (wr ? 4 : 3), "R2 busy cycles", cyc, wr ? 4 : 3);
    // R7: lane select and address
    chk(ceOk, "R7 chip enables follow mask", {28'd0, memCeN}, {28'd0, ~m});
    chk(addrOk, "R7 address held", {13'd0, memAddr}, {13'd0, a});
    if (wr) begin
      for (int l = 0; l < 4; l++) begin
        // R5: pulse only on masked lanes, 2 cycles
        chk(weLow[l] == (m[l] ? 2 : 0), "R5 write pulse length", weLow[l], m[l] ? 2 : 0);
        if (m[l]) refm[a[3:0]][l] = d[l*8 +: 8];
      end
      chk(oeLow == 0, "R5 output enable high on write", oeLow, 0);
      // R6
      chk(holdOk, "R6 hold phase", {31'd0, holdOk}, 1);
      chk(rspCnt == 0, "R4 no response on write", rspCnt, 0);
    end else begin
      // R3
      chk(oeLow == 2, "R3 read phase length", oeLow, 2);
      chk(weLow[0] + weLow[1] + weLow[2] + weLow[3] == 0, "R3 no write enable on read",
          weLow[0] + weLow[1] + weLow[2] + weLow[3], 0);
      chk(driveOk, "R9 no drive on read", {31'd0, driveOk}, 1);
      // R4
      chk(rspCnt == 1 && rspAt == 2, "R4 response timing", rspAt, 2);
      chk(got == expRead(a, m), "R4 read data", got, expRead(a, m));
    end
    // R8: recovered to idle state
    chk(memCeN == 4'hF && memWeN == 4'hF && memOeN && !memDrive, "R8 idle strobes",
        {memCeN, memWeN, 22'd0, memOeN, memDrive}, {4'hF, 4'hF, 22'd0, 1'b1, 1'b0});
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++)
      for (int l = 0; l < 4; l++) begin
        mdl[i][l] = 8'h00;
        refm[i][l] = 8'h00;
      end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(memCeN == 4'hF && memWeN == 4'hF && memOeN && !memDrive && !rspValid,
        "R1 strobes in reset", {memCeN, memWeN, 24'd0}, {4'hF, 4'hF, 24'd0});
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", {31'd0, reqReady}, 1);
    chk(rspValid == 1'b0 && memOeN, "R1 no response after reset", {31'd0, rspValid}, 0);

    // directed corners
    doReq(1, 19'h00003, 4'hF, 32'hDEADBEEF);
    doReq(0, 19'h00003, 4'hF, 32'h0);
    doReq(1, 19'h40003, 4'b0010, 32'h11223344);
    doReq(0, 19'h40003, 4'hF, 32'h0);
    doReq(0, 19'h00003, 4'b1001, 32'h0);
    doReq(1, 19'h00005, 4'h0, 32'hFFFFFFFF);
    doReq(0, 19'h00005, 4'hF, 32'h0);
    doReq(1, 19'h00006, 4'b1100, 32'hCAFEF00D);
    doReq(1, 19'h00006, 4'b0011, 32'h0BADC0DE);
    doReq(0, 19'h00006, 4'hF, 32'h0);

    // random mix, low address bits pick model entry
    for (int n = 0; n < 60; n++) begin
      logic [18:0] a = 19'($urandom);
      doReq(bit'($urandom % 2), a, 4'($urandom), $urandom);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule